// File: doc/BRIEF.md
# Machine-Mode CSR Unit

This block holds the machine-level control and status registers of a small 32-bit RISC-V core that runs only in machine mode. The execute stage gives it a 12-bit register address, an operation code and a source operand, taken either from a register or from a zero-extended 5-bit immediate. The unit returns the register's old value in the same cycle and applies the write, set or clear at the next rising clock edge. It also raises an illegal-instruction flag for accesses the core has to trap.

The trap logic of the core uses two further ports. A trap-entry strobe saves the faulting PC and the cause and masks interrupts. A return strobe restores the interrupt enable. The interrupt controller drives a 32-bit pending vector, which the unit shows through a read-only register. The unit drives the global interrupt enable, the per-line enable mask, the trap target address and the return PC straight to the rest of the core.

Top module: `mcsr_unit`

## Requirements
- R1: The status register (0x300) resets to 0. Only bit 3 (global interrupt enable) and bit 7 (saved enable) can be written, and every other bit reads 0.
- R2: Address 0x301 always reads 0x4000_1104, and writes to it change nothing and are not flagged.
- R3: The enable mask at 0x304 resets to 0 and holds any 32-bit value. 0x344 reads the `irq_pending` input in the same cycle and ignores writes.
- R4: The trap vector at 0x305 resets to 0, bits [1:0] always read 00 (direct mode), and the upper 30 bits are writable.
- R5: Scratch (0x340) resets to 0 and holds any value. The return PC (0x341) resets to 0 and its bit 0 always reads 0.
- R6: The cause register (0x342) reads {interrupt flag in bit 31, zeros, code in [3:0]}. A write takes effect only if bits [30:4] are 0 and the code is 0 to 7 or 11 for an exception, or 3, 7 or 11 for an interrupt. Any other write leaves the old value.
- R7: Addresses 0x302, 0x303, 0x310 and 0x343 read 0 and accept writes without effect or flag. 0xF11 and 0xF15 read 0.
- R8: 0xF12 reads 37, 0xF13 reads {fork flag in bit 31, zeros, major in [15:8], minor in [7:4], patch in [3:0]} (default version 1.2.3, fork 0, so 0x0000_0123), and 0xF14 reads the `HART_ID` parameter.
- R9: `csr_op` 00 only reads, 01 writes the source, 10 sets the source bits and 11 clears them. When `csr_use_imm` is 1 the source is `csr_zimm` zero-extended, otherwise `csr_rs1`. `csr_rdata` shows the value before the operation, and the new value is visible from the next cycle.
- R10: A set or clear with a zero source writes nothing and is never flagged, even at a read-only address.
- R11: `csr_illegal` is 1 for an access to any address outside the ones listed above, and for a write (op 01, or set or clear with a nonzero source) to an address with bits [11:10] = 11. A flagged access changes no state.
- R12: On `trap_en` the saved enable takes the global enable, the global enable clears, the return PC takes `trap_pc` with bit 0 cleared, and the cause takes {`trap_is_irq`, `trap_code`}.
- R13: On `mret_en` (with no trap) the global enable takes the saved enable and the saved enable becomes 1.
- R14: Trap entry takes priority over return, and both take priority over a CSR write in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csr_addr | input | 12 | Register address |
| csr_use_imm | input | 1 | Select immediate source |
| csr_rs1 | input | 32 | Register source operand |
| csr_zimm | input | 5 | Immediate source operand |
| csr_rdata | output | 32 | Old value of the addressed register |
| csr_illegal | output | 1 | Access must trap as illegal instruction |
| trap_en | input | 1 | Trap entry strobe |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Trap cause code |
| trap_pc | input | 32 | PC to save on trap |
| mret_en | input | 1 | Trap return strobe |
| irq_pending | input | 32 | Pending interrupt lines |
| irq_global_en | output | 1 | Global interrupt enable |
| irq_enable_mask | output | 32 | Per-line interrupt enables |
| trap_vector | output | 32 | Trap target address |
| ret_pc | output | 32 | Saved return PC |

## Verification
The read data and the illegal flag are combinational. They are due in the same cycle as the access, so the bench samples them 1 ns after driving the inputs, before the clock rises. Every state change from a write, a trap or a return takes one clock edge. The bench updates its reference model at that edge, then compares the four state outputs 1 ns later and reads the registers back through the access port in the following cycle. This shows that each effect appears exactly one cycle after its stimulus and not before.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ISA,
      SEL_IE,
      SEL_TVEC,
      SEL_SCRATCH,
      SEL_EPC,
      SEL_CAUSE,
      SEL_IP,
      SEL_ZERO,
      SEL_ARCH,
      SEL_IMPL,
      SEL_HART
   } csr_sel_e;

   localparam logic [11:0] A_STATUS  = 12'h300;
   localparam logic [11:0] A_ISA     = 12'h301;
   localparam logic [11:0] A_EDELEG  = 12'h302;
   localparam logic [11:0] A_IDELEG  = 12'h303;
   localparam logic [11:0] A_IE      = 12'h304;
   localparam logic [11:0] A_TVEC    = 12'h305;
   localparam logic [11:0] A_STATH   = 12'h310;
   localparam logic [11:0] A_SCRATCH = 12'h340;
   localparam logic [11:0] A_EPC     = 12'h341;
   localparam logic [11:0] A_CAUSE   = 12'h342;
   localparam logic [11:0] A_TVAL    = 12'h343;
   localparam logic [11:0] A_IP      = 12'h344;
   localparam logic [11:0] A_VENDOR  = 12'hF11;
   localparam logic [11:0] A_ARCH    = 12'hF12;
   localparam logic [11:0] A_IMPL    = 12'hF13;
   localparam logic [11:0] A_HART    = 12'hF14;
   localparam logic [11:0] A_CFGPTR  = 12'hF15;

   localparam int ST_IE_BIT  = 3;
   localparam int ST_PIE_BIT = 7;

   localparam logic [31:0] ISA_WORD = 32'h4000_1104;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
   import mcsr_pkg::*;
(
   input  logic [11:0] addr,
   output csr_sel_e    sel,
   output logic        ro_space
);

   always_comb begin
      case (addr)
         A_STATUS:  sel = SEL_STATUS;
         A_ISA:     sel = SEL_ISA;
         A_IE:      sel = SEL_IE;
         A_TVEC:    sel = SEL_TVEC;
         A_SCRATCH: sel = SEL_SCRATCH;
         A_EPC:     sel = SEL_EPC;
         A_CAUSE:   sel = SEL_CAUSE;
         A_IP:      sel = SEL_IP;
         A_EDELEG, A_IDELEG, A_STATH, A_TVAL,
         A_VENDOR, A_CFGPTR: sel = SEL_ZERO;
         A_ARCH:    sel = SEL_ARCH;
         A_IMPL:    sel = SEL_IMPL;
         A_HART:    sel = SEL_HART;
         default:   sel = SEL_NONE;
      endcase
   end

   // bits [11:10] = 11 mark the read-only address space
   assign ro_space = (addr[11:10] == 2'b11);

endmodule

// File: rtl/mcsr_rmw.sv
module mcsr_rmw
   import mcsr_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] old_val,
   input  logic [W-1:0] src,
   output logic [W-1:0] new_val,
   output logic         wants_write
);

   csr_op_e op_e;
   logic    src_nz;

   assign op_e   = csr_op_e'(op);
   assign src_nz = |src;

   always_comb begin
      case (op_e)
         OP_WRITE: begin new_val = src;            wants_write = 1'b1;   end
         OP_SET:   begin new_val = old_val | src;  wants_write = src_nz; end
         OP_CLEAR: begin new_val = old_val & ~src; wants_write = src_nz; end
         default:  begin new_val = old_val;        wants_write = 1'b0;   end
      endcase
   end

endmodule

// File: rtl/mcsr_cause_check.sv
module mcsr_cause_check #(
   parameter int                   CODE_W    = 4,
   parameter logic [2**CODE_W-1:0] EXC_LEGAL = '1,
   parameter logic [2**CODE_W-1:0] IRQ_LEGAL = '1
) (
   input  logic [31:0]       val,
   output logic              legal,
   output logic              is_irq,
   output logic [CODE_W-1:0] code
);

   logic upper_clear;

   assign is_irq      = val[31];
   assign code        = val[CODE_W-1:0];
   assign upper_clear = (val[30:CODE_W] == '0);
   assign legal       = upper_clear && (is_irq ? IRQ_LEGAL[code] : EXC_LEGAL[code]);

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
   import mcsr_pkg::*;
#(
   parameter logic [31:0]          HART_ID    = 32'd0,
   parameter logic [31:0]          ARCH_ID    = 32'd37,
   parameter int                   VER_MAJOR  = 1,
   parameter int                   VER_MINOR  = 2,
   parameter int                   VER_PATCH  = 3,
   parameter bit                   FORK_BUILD = 1'b0,
   parameter int                   CODE_W     = 4,
   parameter logic [2**CODE_W-1:0] EXC_LEGAL  = 16'h08FF,
   parameter logic [2**CODE_W-1:0] IRQ_LEGAL  = 16'h0888
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_en,
   input  logic [1:0]        csr_op,
   input  logic [11:0]       csr_addr,
   input  logic              csr_use_imm,
   input  logic [31:0]       csr_rs1,
   input  logic [4:0]        csr_zimm,
   output logic [31:0]       csr_rdata,
   output logic              csr_illegal,
   input  logic              trap_en,
   input  logic              trap_is_irq,
   input  logic [CODE_W-1:0] trap_code,
   input  logic [31:0]       trap_pc,
   input  logic              mret_en,
   input  logic [31:0]       irq_pending,
   output logic              irq_global_en,
   output logic [31:0]       irq_enable_mask,
   output logic [31:0]       trap_vector,
   output logic [31:0]       ret_pc
);

   localparam int          PAD_W     = 31 - CODE_W;
   localparam logic [31:0] IMPL_BASE = {16'h0, 8'(VER_MAJOR), 4'(VER_MINOR), 4'(VER_PATCH)};

   // elaboration-time parameter checks
   if (CODE_W < 2 || CODE_W > 5) begin : g_bad_code_w
      $error("mcsr_unit: CODE_W must be in 2..5");
   end
   if (VER_MAJOR < 0 || VER_MAJOR > 255) begin : g_bad_major
      $error("mcsr_unit: VER_MAJOR must fit 8 bits");
   end
   if (VER_MINOR < 0 || VER_MINOR > 15) begin : g_bad_minor
      $error("mcsr_unit: VER_MINOR must fit 4 bits");
   end
   if (VER_PATCH < 0 || VER_PATCH > 15) begin : g_bad_patch
      $error("mcsr_unit: VER_PATCH must fit 4 bits");
   end

   logic [31:0] impl_word;
   if (FORK_BUILD) begin : g_fork
      assign impl_word = IMPL_BASE | 32'h8000_0000;
   end else begin : g_official
      assign impl_word = IMPL_BASE;
   end

   // state
   logic              st_ie, st_pie;
   logic [31:0]       ie_q, tvec_q, scratch_q, epc_q;
   logic              cause_irq_q;
   logic [CODE_W-1:0] cause_code_q;

   // access path
   csr_sel_e    sel;
   logic        ro_space;
   logic [31:0] src, old_val, new_val;
   logic        wants_write, wr_ok;
   logic        cause_legal, cause_wirq;
   logic [CODE_W-1:0] cause_wcode;

   assign src = csr_use_imm ? {27'h0, csr_zimm} : csr_rs1;

   mcsr_decode u_dec (
      .addr     (csr_addr),
      .sel      (sel),
      .ro_space (ro_space)
   );

   always_comb begin
      old_val = '0;
      case (sel)
         SEL_STATUS: begin
            old_val[ST_IE_BIT]  = st_ie;
            old_val[ST_PIE_BIT] = st_pie;
         end
         SEL_ISA:     old_val = ISA_WORD;
         SEL_IE:      old_val = ie_q;
         SEL_TVEC:    old_val = tvec_q;
         SEL_SCRATCH: old_val = scratch_q;
         SEL_EPC:     old_val = epc_q;
         SEL_CAUSE:   old_val = {cause_irq_q, {PAD_W{1'b0}}, cause_code_q};
         SEL_IP:      old_val = irq_pending;
         SEL_ARCH:    old_val = ARCH_ID;
         SEL_IMPL:    old_val = impl_word;
         SEL_HART:    old_val = HART_ID;
         default:     old_val = '0;
      endcase
   end

   mcsr_rmw #(.W(32)) u_rmw (
      .op          (csr_op),
      .old_val     (old_val),
      .src         (src),
      .new_val     (new_val),
      .wants_write (wants_write)
   );

   mcsr_cause_check #(
      .CODE_W    (CODE_W),
      .EXC_LEGAL (EXC_LEGAL),
      .IRQ_LEGAL (IRQ_LEGAL)
   ) u_cause (
      .val    (new_val),
      .legal  (cause_legal),
      .is_irq (cause_wirq),
      .code   (cause_wcode)
   );

   assign csr_rdata   = old_val;
   assign csr_illegal = csr_en && ((sel == SEL_NONE) || (ro_space && wants_write));
   assign wr_ok       = csr_en && !csr_illegal && wants_write && !trap_en && !mret_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_ie        <= 1'b0;
         st_pie       <= 1'b0;
         ie_q         <= '0;
         tvec_q       <= '0;
         scratch_q    <= '0;
         epc_q        <= '0;
         cause_irq_q  <= 1'b0;
         cause_code_q <= '0;
      end else if (trap_en) begin
         st_pie       <= st_ie;
         st_ie        <= 1'b0;
         epc_q        <= {trap_pc[31:1], 1'b0};
         cause_irq_q  <= trap_is_irq;
         cause_code_q <= trap_code;
      end else if (mret_en) begin
         st_ie  <= st_pie;
         st_pie <= 1'b1;
      end else if (wr_ok) begin
         case (sel)
            SEL_STATUS: begin
               st_ie  <= new_val[ST_IE_BIT];
               st_pie <= new_val[ST_PIE_BIT];
            end
            SEL_IE:      ie_q      <= new_val;
            SEL_TVEC:    tvec_q    <= {new_val[31:2], 2'b00};
            SEL_SCRATCH: scratch_q <= new_val;
            SEL_EPC:     epc_q     <= {new_val[31:1], 1'b0};
            SEL_CAUSE: begin
               if (cause_legal) begin
                  cause_irq_q  <= cause_wirq;
                  cause_code_q <= cause_wcode;
               end
            end
            default: ;
         endcase
      end
   end

   assign irq_global_en   = st_ie;
   assign irq_enable_mask = ie_q;
   assign trap_vector     = tvec_q;
   assign ret_pc          = epc_q;

   // ---------------- assertions ----------------
   a_r12_trap_masks_irq: assert property (@(posedge clk) disable iff (!rst_n)
      trap_en |=> !irq_global_en);

   a_r12_trap_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
      trap_en |=> ret_pc == {$past(trap_pc[31:1]), 1'b0});

   a_r13_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_en && !trap_en) |=> irq_global_en == $past(st_pie));

   a_r11_flagged_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && csr_illegal && !trap_en && !mret_en) |=>
         $stable(scratch_q) && $stable(ie_q) && $stable(tvec_q) && $stable(epc_q));

   a_r6_bad_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && sel == SEL_CAUSE && !cause_legal) |=>
         $stable(cause_code_q) && $stable(cause_irq_q));

   a_r7_zero_reg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && (csr_addr == A_TVAL || csr_addr == A_STATH)) |->
         (csr_rdata == 32'h0) && !csr_illegal);

   a_r14_trap_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_en && csr_en && csr_addr == A_SCRATCH) |=> $stable(scratch_q));

endmodule

// File: tb/mcsr_unit_test.sv
module mcsr_unit_test;

   localparam logic [31:0] HART = 32'h0000_0005;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_en = 1'b0;
   logic [1:0]  csr_op = 2'b00;
   logic [11:0] csr_addr = 12'h0;
   logic        csr_use_imm = 1'b0;
   logic [31:0] csr_rs1 = 32'h0;
   logic [4:0]  csr_zimm = 5'h0;
   logic [31:0] csr_rdata;
   logic        csr_illegal;
   logic        trap_en = 1'b0;
   logic        trap_is_irq = 1'b0;
   logic [3:0]  trap_code = 4'h0;
   logic [31:0] trap_pc = 32'h0;
   logic        mret_en = 1'b0;
   logic [31:0] irq_pending = 32'h0;
   logic        irq_global_en;
   logic [31:0] irq_enable_mask, trap_vector, ret_pc;

   always #4 clk = ~clk;   // 125 MHz

   mcsr_unit #(.HART_ID(HART)) uut (
      .clk(clk), .rst_n(rst_n),
      .csr_en(csr_en), .csr_op(csr_op), .csr_addr(csr_addr),
      .csr_use_imm(csr_use_imm), .csr_rs1(csr_rs1), .csr_zimm(csr_zimm),
      .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
      .trap_en(trap_en), .trap_is_irq(trap_is_irq), .trap_code(trap_code),
      .trap_pc(trap_pc), .mret_en(mret_en), .irq_pending(irq_pending),
      .irq_global_en(irq_global_en), .irq_enable_mask(irq_enable_mask),
      .trap_vector(trap_vector), .ret_pc(ret_pc)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   bit          m_ie, m_pie;
   logic [31:0] m_ien, m_tvec, m_scr, m_epc, m_cause;

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit known(logic [11:0] a);
      case (a)
         12'h300, 12'h301, 12'h302, 12'h303, 12'h304, 12'h305, 12'h310,
         12'h340, 12'h341, 12'h342, 12'h343, 12'h344,
         12'hF11, 12'hF12, 12'hF13, 12'hF14, 12'hF15: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] mread(logic [11:0] a, logic [31:0] pend);
      case (a)
         12'h300: return (m_ie ? 32'h8 : 32'h0) | (m_pie ? 32'h80 : 32'h0);
         12'h301: return 32'h4000_1104;
         12'h304: return m_ien;
         12'h305: return m_tvec;
         12'h340: return m_scr;
         12'h341: return m_epc;
         12'h342: return m_cause;
         12'h344: return pend;
         12'hF12: return 32'd37;
         12'hF13: return 32'h0000_0123;
         12'hF14: return HART;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit cause_ok(logic [31:0] v);
      int c = int'(v[3:0]);
      if (v[30:4] != 0) return 1'b0;
      if (v[31]) return (c == 3 || c == 7 || c == 11);
      return (c <= 7 || c == 11);
   endfunction

   task automatic step(string tag, bit en, logic [1:0] op, logic [11:0] a, bit imm,
                       logic [31:0] rs1, logic [4:0] zi, bit trap, bit tirq,
                       logic [3:0] tcode, logic [31:0] tpc, bit mret, logic [31:0] pend);
      logic [31:0] src, old, nv;
      bit wants, ill;
      @(negedge clk);
      csr_en = en; csr_op = op; csr_addr = a; csr_use_imm = imm; csr_rs1 = rs1;
      csr_zimm = zi; trap_en = trap; trap_is_irq = tirq; trap_code = tcode;
      trap_pc = tpc; mret_en = mret; irq_pending = pend;
      #1;
      src   = imm ? {27'h0, zi} : rs1;
      old   = mread(a, pend);
      wants = (op == 2'b01) || ((op != 2'b00) && (src != 0));
      ill   = en && (!known(a) || (a[11:10] == 2'b11 && wants));
      if (en) begin
         check(tag, "rdata", csr_rdata, old);
         check(tag, "illegal", {31'h0, csr_illegal}, {31'h0, ill});
      end
      @(posedge clk);
      if (trap) begin
         m_pie = m_ie; m_ie = 1'b0; m_epc = tpc & ~32'h1;
         m_cause = {tirq, 27'h0, tcode};
      end else if (mret) begin
         m_ie = m_pie; m_pie = 1'b1;
      end else if (en && !ill && wants) begin
         nv = (op == 2'b01) ? src : (op == 2'b10) ? (old | src) : (old & ~src);
         case (a)
            12'h300: begin m_ie = nv[3]; m_pie = nv[7]; end
            12'h304: m_ien = nv;
            12'h305: m_tvec = nv & ~32'h3;
            12'h340: m_scr = nv;
            12'h341: m_epc = nv & ~32'h1;
            12'h342: if (cause_ok(nv)) m_cause = nv;
            default: ;
         endcase
      end
      #1;
      check(tag, "irq_global_en", {31'h0, irq_global_en}, {31'h0, m_ie});
      check(tag, "irq_enable_mask", irq_enable_mask, m_ien);
      check(tag, "trap_vector", trap_vector, m_tvec);
      check(tag, "ret_pc", ret_pc, m_epc);
   endtask

   task automatic acc(string tag, logic [1:0] op, logic [11:0] a, logic [31:0] v);
      step(tag, 1'b1, op, a, 1'b0, v, 5'h0, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0, 32'h0);
   endtask

   task automatic acc_imm(string tag, logic [1:0] op, logic [11:0] a, logic [4:0] z);
      step(tag, 1'b1, op, a, 1'b1, 32'hFFFF_FFFF, z, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0, 32'h0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_ie = 0; m_pie = 0; m_ien = 0; m_tvec = 0; m_scr = 0; m_epc = 0; m_cause = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 R3 R4 R5 R6: reset values
      acc("R1", 2'b00, 12'h300, 0);
      acc("R3", 2'b00, 12'h304, 0);
      acc("R4", 2'b00, 12'h305, 0);
      acc("R5", 2'b00, 12'h340, 0);
      acc("R5", 2'b00, 12'h341, 0);
      acc("R6", 2'b00, 12'h342, 0);

      // R2: ISA word is constant
      acc("R2", 2'b01, 12'h301, 32'hFFFF_FFFF);
      acc("R2", 2'b00, 12'h301, 0);

      // R1: only bits 3 and 7 writable
      acc("R1", 2'b01, 12'h300, 32'hFFFF_FFFF);
      acc("R1", 2'b00, 12'h300, 0);
      acc_imm("R1", 2'b11, 12'h300, 5'h08);
      acc("R1", 2'b00, 12'h300, 0);

      // R3: enable mask and pending mirror
      acc("R3", 2'b01, 12'h304, 32'hA5A5_5A5A);
      acc("R3", 2'b00, 12'h304, 0);
      step("R3", 1, 2'b00, 12'h344, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0000_0880);
      step("R3", 1, 2'b01, 12'h344, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 32'h0000_0008);
      step("R3", 1, 2'b00, 12'h344, 0, 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000);

      // R4: direct mode forced
      acc("R4", 2'b01, 12'h305, 32'h1234_5677);
      acc("R4", 2'b00, 12'h305, 0);

      // R5: scratch any value, return PC halfword aligned
      acc("R5", 2'b01, 12'h340, 32'hDEAD_BEEF);
      acc("R5", 2'b00, 12'h340, 0);
      acc("R5", 2'b01, 12'h341, 32'h0000_1003);
      acc("R5", 2'b00, 12'h341, 0);

      // R6: cause legality
      acc("R6", 2'b01, 12'h342, 32'h8000_000B);
      acc("R6", 2'b01, 12'h342, 32'h8000_0005);
      acc("R6", 2'b00, 12'h342, 0);
      acc("R6", 2'b01, 12'h342, 32'h0000_0009);
      acc("R6", 2'b01, 12'h342, 32'h0000_0002);
      acc("R6", 2'b01, 12'h342, 32'h4000_0002);
      acc("R6", 2'b00, 12'h342, 0);

      // R7: zero-reading unimplemented registers
      acc("R7", 2'b01, 12'h302, 32'hFFFF_FFFF);
      acc("R7", 2'b10, 12'h303, 32'h0000_00FF);
      acc("R7", 2'b01, 12'h310, 32'hFFFF_FFFF);
      acc("R7", 2'b01, 12'h343, 32'h1234_5678);
      acc("R7", 2'b00, 12'h343, 0);
      acc("R7", 2'b00, 12'hF11, 0);
      acc("R7", 2'b00, 12'hF15, 0);

      // R8: identification values
      acc("R8", 2'b00, 12'hF12, 0);
      acc("R8", 2'b00, 12'hF13, 0);
      acc("R8", 2'b00, 12'hF14, 0);

      // R9: set by register, clear by immediate, old value returned
      acc("R9", 2'b10, 12'h340, 32'h0000_F000);
      acc_imm("R9", 2'b11, 12'h340, 5'h0F);
      acc_imm("R9", 2'b01, 12'h340, 5'h15);
      acc("R9", 2'b00, 12'h340, 0);

      // R10: zero-source set/clear is a pure read
      acc("R10", 2'b10, 12'hF12, 32'h0);
      acc_imm("R10", 2'b11, 12'hF14, 5'h0);
      acc_imm("R10", 2'b10, 12'h340, 5'h0);

      // R11: illegal accesses flagged, no effect
      acc("R11", 2'b00, 12'h7C0, 0);
      acc("R11", 2'b01, 12'h345, 32'hFFFF_FFFF);
      acc("R11", 2'b01, 12'hF12, 32'h1);
      acc_imm("R11", 2'b10, 12'hF14, 5'h1);
      acc("R11", 2'b11, 12'hF11, 32'h4);
      acc("R11", 2'b00, 12'h340, 0);

      // R12: trap entry
      acc("R12", 2'b01, 12'h300, 32'h0000_0008);
      step("R12", 0, 2'b00, 12'h0, 0, 0, 0, 1, 1, 4'd7, 32'h0000_2001, 0, 0);
      acc("R12", 2'b00, 12'h300, 0);
      acc("R12", 2'b00, 12'h342, 0);
      acc("R12", 2'b00, 12'h341, 0);

      // R13: trap return
      step("R13", 0, 2'b00, 12'h0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      acc("R13", 2'b00, 12'h300, 0);
      step("R13", 0, 2'b00, 12'h0, 0, 0, 0, 0, 0, 0, 0, 1, 0);

      // R14: priority of trap and return over a CSR write
      step("R14", 1, 2'b01, 12'h340, 0, 32'h5555_5555, 0, 1, 0, 4'd2, 32'h0000_3000, 1, 0);
      acc("R14", 2'b00, 12'h340, 0);
      acc("R14", 2'b00, 12'h300, 0);
      step("R14", 1, 2'b01, 12'h304, 0, 32'h0, 0, 0, 0, 0, 0, 1, 0);
      acc("R14", 2'b00, 12'h304, 0);

      // reset again returns everything to zero (R1)
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk);
      m_ie = 0; m_pie = 0; m_ien = 0; m_tvec = 0; m_scr = 0; m_epc = 0; m_cause = 0;
      @(negedge clk); rst_n = 1'b1;
      acc("R1", 2'b00, 12'h300, 0);
      acc("R6", 2'b00, 12'h342, 0);

      @(negedge clk);
      csr_en = 1'b0;
      finish_run();
   end

endmodule